// File: doc/BRIEF.md
# Memory Barrier Issue Gate

This block sits between an in-order issue stage and the load-store unit. It decides, cycle by cycle, which classes of instruction may leave issue so that memory barriers keep their ordering meaning. Each offered instruction carries a class (load, store or other) and a barrier kind. The kinds are a full data barrier, a load-only data barrier, a synchronization barrier, a load-acquire and a store-release. The gate counts loads and stores that have issued but not completed. It uses completion pulses from the memory side to decrement those counts.

The full data barrier and the synchronization barrier first wait for every earlier access to finish. They then run a request/response exchange on a bus barrier channel and retire when the response comes back. The load-only data barrier and the load-acquire never touch the bus; they resolve once the outstanding load count is zero. The store-release is held at issue until nothing earlier is outstanding. After it issues it blocks nothing.

Only one barrier is in flight at a time. A shareability domain tag given with a barrier is latched and shown on the bus channel. Every stall output is a function of registered state only, so issue logic never sees a path from its own offer back to its stall.

Top module: `mem_barrier_gate`

## Requirements
- R1: After synchronous reset, both outstanding counts are zero, every stall output and `bus_bar_req` are low, `bar_retire` is low, and the gate is idle.
- R2: Class codes are 0 other, 1 load and 2 store. The outstanding load and store counts are CNT_W bits wide. Each count rises by one on an accepted issue of its class and falls by one on its completion pulse, and holds when both happen in the same cycle. A count never rises above its maximum and never falls below zero. `stall_load` (or `stall_store`) is high while its count is at maximum.
- R3: A full data barrier (kind code 1, class other) holds `stall_load` and `stall_store` high and leaves `stall_other` low. It raises `bus_bar_req` only in the cycle after both counts were seen at zero.
- R4: A synchronization barrier (kind code 3, class other) acts as R3 and also holds `stall_other` high until it retires.
- R5: `bus_bar_req` stays high until a cycle with `bus_bar_ready` high. The gate then waits for a one-cycle `bus_bar_resp`. `bar_retire` pulses for exactly one cycle, in the cycle after the response, and all stalls from the barrier drop in that same cycle.
- R6: A load-only data barrier (kind code 2, class other) holds loads and stores until the load count is seen at zero. It then retires without raising `bus_bar_req`.
- R7: A load-acquire (kind code 4, class load) issues as a load and is counted. It then stalls later loads and stores until the load count is seen at zero, and retires with no bus traffic.
- R8: A store-release (kind code 5, class store) is refused while either count is nonzero or a barrier is active (`stall_release` high). When accepted, it is counted as a store and pulses `bar_retire` in the next cycle without stalling anything.
- R9: While a barrier is active, `stall_barrier` is high and any further barrier offered at issue is refused and leaves the active barrier unchanged.
- R10: The domain tag given with an accepted bus barrier appears on `bus_bar_dom` while the request is high, and stays stable until the request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | An instruction is offered at issue |
| iss_class | input | 2 | Class: 0 other, 1 load, 2 store |
| iss_bar | input | 3 | Barrier kind: 0 none, 1 full data, 2 load-only data, 3 sync, 4 acquire, 5 release |
| iss_dom | input | DOM_W | Domain tag for a barrier |
| ld_done | input | 1 | One load completed |
| st_done | input | 1 | One store completed |
| bus_bar_ready | input | 1 | Bus accepts the barrier request |
| bus_bar_resp | input | 1 | Bus barrier response pulse |
| stall_load | output | 1 | Loads may not issue |
| stall_store | output | 1 | Stores may not issue |
| stall_other | output | 1 | Non-memory instructions may not issue |
| stall_barrier | output | 1 | No barrier may issue |
| stall_release | output | 1 | A store-release may not issue |
| bus_bar_req | output | 1 | Barrier request to the bus |
| bus_bar_dom | output | DOM_W | Domain tag of the requested barrier |
| bar_retire | output | 1 | One-cycle barrier retire pulse |

## Verification
The bench builds the gate with CNT_W = 3 and DOM_W = 2. The narrow counters put the saturation limit of seven within a few cycles, so the bench can issue past the limit and then drain past zero and watch for refused issues and for a count that holds rather than wraps. The two-bit domain lets a nonzero tag be followed through the whole time a request is held. A table of single-cycle steps drives every barrier kind through its drain, bus and retire phases, with the bus ready and response delayed.

// File: rtl/mbg_pkg.sv
package mbg_pkg;

  typedef enum logic [1:0] {
    CL_OTHER = 2'd0,
    CL_LOAD  = 2'd1,
    CL_STORE = 2'd2
  } iclass_e;

  typedef enum logic [2:0] {
    BK_NONE  = 3'd0,
    BK_FULL  = 3'd1,
    BK_LDONL = 3'd2,
    BK_SYNC  = 3'd3,
    BK_ACQ   = 3'd4,
    BK_REL   = 3'd5
  } bkind_e;

  typedef enum logic [2:0] {
    GS_IDLE  = 3'd0,
    GS_DRAIN = 3'd1,
    GS_REQ   = 3'd2,
    GS_RSP   = 3'd3,
    GS_LWAIT = 3'd4
  } gstate_e;

endpackage

// File: rtl/mbg_sat_cnt.sv
module mbg_sat_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic             full,
  output logic             zero
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  assign full = (cnt == CMAX);
  assign zero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else begin
      case ({inc, dec})
        2'b10:   if (!full) cnt <= cnt + 1'b1;
        2'b01:   if (!zero) cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (cnt == CMAX && inc && !dec) |=> (cnt == CMAX)); // R2
  AST_NO_UNDER: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0 && dec && !inc) |=> (cnt == '0)); // R2
  AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (inc && dec) |=> $stable(cnt)); // R2

endmodule

// File: rtl/mbg_seq.sv
module mbg_seq
  import mbg_pkg::*;
#(
  parameter int DOM_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bar_go,
  input  logic [2:0]       bar_kind,
  input  logic             rel_go,
  input  logic [DOM_W-1:0] dom_in,
  input  logic             ld_zero,
  input  logic             st_zero,
  input  logic             bus_ready,
  input  logic             bus_resp,
  output logic             active,
  output logic             sync_kind,
  output logic             bus_req,
  output logic [DOM_W-1:0] bus_dom,
  output logic             retire
);
  gstate_e          st;
  logic             sync_q;
  logic [DOM_W-1:0] dom_q;
  logic             ret_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= GS_IDLE;
      sync_q <= 1'b0;
      dom_q  <= '0;
      ret_q  <= 1'b0;
    end else begin
      ret_q <= 1'b0;
      case (st)
        GS_IDLE: begin
          if (bar_go) begin
            dom_q  <= dom_in;
            sync_q <= (bar_kind == BK_SYNC);
            if (bar_kind == BK_FULL || bar_kind == BK_SYNC) st <= GS_DRAIN;
            else                                            st <= GS_LWAIT;
          end else if (rel_go) begin
            ret_q <= 1'b1;
          end
        end
        GS_DRAIN: if (ld_zero && st_zero) st <= GS_REQ;
        GS_REQ:   if (bus_ready) st <= GS_RSP;
        GS_RSP: begin
          if (bus_resp) begin
            st    <= GS_IDLE;
            ret_q <= 1'b1;
          end
        end
        GS_LWAIT: begin
          if (ld_zero) begin
            st    <= GS_IDLE;
            ret_q <= 1'b1;
          end
        end
        default: st <= GS_IDLE;
      endcase
    end
  end

  assign active    = (st != GS_IDLE);
  assign sync_kind = sync_q;
  assign bus_req   = (st == GS_REQ);
  assign bus_dom   = dom_q;
  assign retire    = ret_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ready) |=> bus_req); // R5
  AST_RSP_RETIRE: assert property (@(posedge clk) disable iff (rst)
    (st == GS_RSP && bus_resp) |=> (retire && !active)); // R5
  AST_RETIRE_PULSE: assert property (@(posedge clk) disable iff (rst)
    retire |=> !retire); // R5
  AST_LOCAL_NO_BUS: assert property (@(posedge clk) disable iff (rst)
    (st == GS_LWAIT) |=> !bus_req); // R6

endmodule

// File: rtl/mem_barrier_gate.sv
module mem_barrier_gate
  import mbg_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int DOM_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             iss_valid,
  input  logic [1:0]       iss_class,
  input  logic [2:0]       iss_bar,
  input  logic [DOM_W-1:0] iss_dom,
  input  logic             ld_done,
  input  logic             st_done,
  input  logic             bus_bar_ready,
  input  logic             bus_bar_resp,
  output logic             stall_load,
  output logic             stall_store,
  output logic             stall_other,
  output logic             stall_barrier,
  output logic             stall_release,
  output logic             bus_bar_req,
  output logic [DOM_W-1:0] bus_bar_dom,
  output logic             bar_retire
);
  localparam int NCNT = 2; // index 0 loads, index 1 stores

  logic [NCNT-1:0]  inc_v, dec_v, full_v, zero_v;
  logic [CNT_W-1:0] cnt_v [NCNT];
  logic             active, sync_kind;
  logic             ld_ok, st_ok, ot_ok, fire, bar_go, rel_go;

  genvar gi;
  generate
    for (gi = 0; gi < NCNT; gi++) begin : g_cnt
      mbg_sat_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk (clk),
        .rst (rst),
        .inc (inc_v[gi]),
        .dec (dec_v[gi]),
        .cnt (cnt_v[gi]),
        .full(full_v[gi]),
        .zero(zero_v[gi])
      );
    end
  endgenerate

  assign stall_load    = active | full_v[0];
  assign stall_store   = active | full_v[1];
  assign stall_other   = active & sync_kind;
  assign stall_barrier = active;
  assign stall_release = active | ~zero_v[0] | ~zero_v[1];

  always_comb begin
    ld_ok = (iss_class == CL_LOAD) && !stall_load &&
            (iss_bar == BK_NONE || iss_bar == BK_ACQ);
    st_ok = (iss_class == CL_STORE) && !stall_store &&
            (iss_bar == BK_NONE || (iss_bar == BK_REL && !stall_release));
    ot_ok = (iss_class == CL_OTHER) && !stall_other &&
            (iss_bar == BK_NONE ||
             ((iss_bar == BK_FULL || iss_bar == BK_LDONL || iss_bar == BK_SYNC) && !active));
    fire   = iss_valid && (ld_ok || st_ok || ot_ok);
    bar_go = fire && (iss_bar == BK_FULL || iss_bar == BK_LDONL ||
                      iss_bar == BK_SYNC || iss_bar == BK_ACQ);
    rel_go = fire && (iss_bar == BK_REL);
    inc_v  = {fire && iss_class == CL_STORE, fire && iss_class == CL_LOAD};
    dec_v  = {st_done, ld_done};
  end

  mbg_seq #(.DOM_W(DOM_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .bar_go   (bar_go),
    .bar_kind (iss_bar),
    .rel_go   (rel_go),
    .dom_in   (iss_dom),
    .ld_zero  (zero_v[0]),
    .st_zero  (zero_v[1]),
    .bus_ready(bus_bar_ready),
    .bus_resp (bus_bar_resp),
    .active   (active),
    .sync_kind(sync_kind),
    .bus_req  (bus_bar_req),
    .bus_dom  (bus_bar_dom),
    .retire   (bar_retire)
  );

  AST_DRAIN_BEFORE_REQ: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_bar_req) |-> $past(zero_v[0] && zero_v[1])); // R3
  AST_DOM_STABLE: assert property (@(posedge clk) disable iff (rst)
    (bus_bar_req && !bus_bar_ready) |=> $stable(bus_bar_dom)); // R10
  AST_RETIRE_FREES: assert property (@(posedge clk) disable iff (rst)
    bar_retire |-> !stall_barrier); // R9
  AST_SYNC_HOLDS_OTHER: assert property (@(posedge clk) disable iff (rst)
    (stall_other && !bar_retire) |=> (stall_other || bar_retire)); // R4

endmodule

// File: tb/sim_mem_barrier_gate.sv
`timescale 1ns/1ps
module sim_mem_barrier_gate;
  localparam int CNT_W = 3;
  localparam int DOM_W = 2;
  localparam real HALF = 2.5;
  localparam int NV = 26;

  logic clk = 1'b0, rst = 1'b1;
  logic iss_valid = 1'b0;
  logic [1:0] iss_class = '0;
  logic [2:0] iss_bar = '0;
  logic [DOM_W-1:0] iss_dom = '0;
  logic ld_done = 1'b0, st_done = 1'b0, bus_bar_ready = 1'b0, bus_bar_resp = 1'b0;
  logic stall_load, stall_store, stall_other, stall_barrier, stall_release;
  logic bus_bar_req, bar_retire;
  logic [DOM_W-1:0] bus_bar_dom;

  int checks = 0, errors = 0;

  always #(HALF) clk = ~clk;

  mem_barrier_gate #(.CNT_W(CNT_W), .DOM_W(DOM_W)) u0 (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_class(iss_class),
    .iss_bar(iss_bar), .iss_dom(iss_dom), .ld_done(ld_done), .st_done(st_done),
    .bus_bar_ready(bus_bar_ready), .bus_bar_resp(bus_bar_resp),
    .stall_load(stall_load), .stall_store(stall_store), .stall_other(stall_other),
    .stall_barrier(stall_barrier), .stall_release(stall_release),
    .bus_bar_req(bus_bar_req), .bus_bar_dom(bus_bar_dom), .bar_retire(bar_retire)
  );

  // {valid, class[1:0], kind[2:0], ld_done, st_done, ready, resp,
  //  exp: stall_load, stall_other, stall_release, bus_bar_req, bar_retire}
  localparam logic [14:0] VEC [NV] = '{
    {1'b1, 2'd1, 3'd0, 4'b0000, 5'b00100}, // load issues, R2
    {1'b1, 2'd2, 3'd0, 4'b0000, 5'b00100}, // store issues, R2
    {1'b1, 2'd0, 3'd1, 4'b0000, 5'b10100}, // full barrier accepted, R3
    {1'b1, 2'd1, 3'd0, 4'b1000, 5'b10100}, // load refused, load done, R3
    {1'b0, 2'd0, 3'd0, 4'b0100, 5'b10100}, // store done, still draining, R3
    {1'b0, 2'd0, 3'd0, 4'b0000, 5'b10110}, // drained: request, R3
    {1'b0, 2'd0, 3'd0, 4'b0000, 5'b10110}, // not ready: request held, R5
    {1'b0, 2'd0, 3'd0, 4'b0010, 5'b10100}, // accepted, R5
    {1'b0, 2'd0, 3'd0, 4'b0000, 5'b10100}, // waiting response, R5
    {1'b0, 2'd0, 3'd0, 4'b0001, 5'b00001}, // response: retire, R5
    {1'b0, 2'd0, 3'd0, 4'b0000, 5'b00000}, // retire single cycle, R5
    {1'b1, 2'd0, 3'd3, 4'b0000, 5'b11100}, // sync barrier, R4
    {1'b1, 2'd0, 3'd0, 4'b0000, 5'b11110}, // other refused, request, R4
    {1'b0, 2'd0, 3'd0, 4'b0010, 5'b11100}, // accepted, R4
    {1'b0, 2'd0, 3'd0, 4'b0001, 5'b00001}, // retire, R4
    {1'b1, 2'd1, 3'd0, 4'b0000, 5'b00100}, // load issues, R6
    {1'b1, 2'd0, 3'd2, 4'b0000, 5'b10100}, // load-only barrier, R6
    {1'b0, 2'd0, 3'd0, 4'b1000, 5'b10100}, // load done, R6
    {1'b0, 2'd0, 3'd0, 4'b0000, 5'b00001}, // local retire, no bus, R6
    {1'b1, 2'd1, 3'd4, 4'b0000, 5'b10100}, // acquire load, R7
    {1'b0, 2'd0, 3'd0, 4'b1000, 5'b10100}, // acquire completes, R7
    {1'b0, 2'd0, 3'd0, 4'b0000, 5'b00001}, // acquire retires, R7
    {1'b1, 2'd2, 3'd0, 4'b0000, 5'b00100}, // store issues, R8
    {1'b1, 2'd2, 3'd5, 4'b0100, 5'b00000}, // release refused, store done, R8
    {1'b1, 2'd2, 3'd5, 4'b0000, 5'b00101}, // release issues and retires, R8
    {1'b0, 2'd0, 3'd0, 4'b0100, 5'b00000}  // release store completes, R8
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input logic v, input logic [1:0] c, input logic [2:0] b,
                       input logic ld, input logic sd, input logic rd, input logic rs);
    iss_valid = v; iss_class = c; iss_bar = b;
    ld_done = ld; st_done = sd; bus_bar_ready = rd; bus_bar_resp = rs;
  endtask

  task automatic chk(input logic ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic logic [4:0] obs();
    return {stall_load, stall_other, stall_release, bus_bar_req, bar_retire};
  endfunction

  initial begin
    #(HALF * 2 * 100000);
    errors++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    tick(); tick();
    rst = 1'b0;
    // R1: reset state
    chk({stall_load, stall_store, stall_other, stall_barrier, stall_release,
         bus_bar_req, bar_retire} == 7'b0, "R1 reset outputs",
        {stall_load, stall_store, stall_other, stall_barrier, stall_release,
         bus_bar_req, bar_retire}, 0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][14], VEC[i][13:12], VEC[i][11:9], VEC[i][8], VEC[i][7],
            VEC[i][6], VEC[i][5]);
      tick();
      chk(obs() == VEC[i][4:0], $sformatf("R3/R4/R5/R6/R7/R8 row %0d", i),
          obs(), VEC[i][4:0]);
      if (i == 2) chk(stall_store == 1'b1, "R3 store stalled", stall_store, 1);
    end
    drive(0, 0, 0, 0, 0, 0, 0);

    // R9: second barrier refused while one is active
    drive(1, 1, 0, 0, 0, 0, 0); tick();
    drive(1, 0, 1, 0, 0, 0, 0); tick();
    drive(1, 0, 3, 0, 0, 0, 0); tick();
    chk(stall_barrier == 1'b1, "R9 stall_barrier active", stall_barrier, 1);
    chk(stall_other == 1'b0, "R9 sync refused keeps full kind", stall_other, 0);
    drive(0, 0, 0, 1, 0, 0, 0); tick();
    drive(0, 0, 0, 0, 0, 0, 0); tick();
    drive(0, 0, 0, 0, 0, 1, 0); tick();
    drive(0, 0, 0, 0, 0, 0, 1); tick();
    chk(bar_retire == 1'b1, "R9 first barrier retires", bar_retire, 1);
    drive(0, 0, 0, 0, 0, 0, 0); tick();
    chk(stall_barrier == 1'b0, "R9 gate idle after retire", stall_barrier, 0);

    // R10: domain tag on the bus while request held
    iss_dom = 2'd2;
    drive(1, 0, 3, 0, 0, 0, 0); tick();
    iss_dom = 2'd1;
    drive(0, 0, 0, 0, 0, 0, 0); tick();
    chk(bus_bar_req && bus_bar_dom == 2'd2, "R10 domain on request", bus_bar_dom, 2);
    tick();
    chk(bus_bar_req && bus_bar_dom == 2'd2, "R10 domain held", bus_bar_dom, 2);
    drive(0, 0, 0, 0, 0, 1, 0); tick();
    drive(0, 0, 0, 0, 0, 0, 1); tick();
    drive(0, 0, 0, 0, 0, 0, 0); tick();

    // R2: saturation at 7 with CNT_W = 3
    for (int k = 0; k < 9; k++) begin
      drive(1, 1, 0, 0, 0, 0, 0); tick();
    end
    drive(0, 0, 0, 0, 0, 0, 0);
    chk(stall_load == 1'b1, "R2 load count full stalls loads", stall_load, 1);
    chk(stall_store == 1'b0, "R2 store side free", stall_store, 0);
    for (int k = 0; k < 6; k++) begin
      drive(0, 0, 0, 1, 0, 0, 0); tick();
    end
    chk(stall_load == 1'b0 && stall_release == 1'b1, "R2 one load left",
        {stall_load, stall_release}, 1);
    drive(0, 0, 0, 1, 0, 0, 0); tick();
    chk(stall_release == 1'b0, "R2 count saturated at max, drained", stall_release, 0);
    tick();
    drive(0, 0, 0, 0, 0, 0, 0);
    drive(1, 1, 0, 0, 0, 0, 0); tick();
    chk(stall_release == 1'b1, "R2 no underflow below zero", stall_release, 1);
    drive(1, 1, 0, 1, 0, 0, 0); tick();
    drive(0, 0, 0, 1, 0, 0, 0); tick();
    chk(stall_release == 1'b0, "R2 issue with completion holds", stall_release, 0);

    // R1: reset mid-flight
    drive(1, 2, 0, 0, 0, 0, 0); tick();
    drive(1, 0, 3, 0, 0, 0, 0); tick();
    drive(0, 0, 0, 0, 0, 0, 0);
    rst = 1'b1; tick(); rst = 1'b0;
    chk({stall_load, stall_other, stall_barrier, stall_release, bus_bar_req} == 5'b0,
        "R1 reset clears active barrier and counts",
        {stall_load, stall_other, stall_barrier, stall_release, bus_bar_req}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule